// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block drives the address and access type seen by a memory core during short bursts. On a load cycle it takes a full external address and the read/write type of the new access. On each later advance cycle it steps only the two lowest address bits, so a single address can serve up to four consecutive beats. The upper address bits and the access type do not change until the next load.

The step order is fixed while the block runs. It is sampled from a mode input while reset is held. Interleaved order XORs the start value with the beat number. Linear order adds the beat number to the start value and wraps. A stall input freezes every edge. A load cycle with the select input low ends the access. Advances then do nothing until a new load arrives. Advances never look at the select or write inputs.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `valid_o`, `addr_o` and `wr_o` to zero and captures `order_sel` as the step order (1 = interleaved, 0 = linear).
- R2: On an edge with `stall` = 0, `adv` = 0 and `sel` = 1, the block loads a new access. After that edge `valid_o` = 1, `addr_o` equals `addr_i` and `wr_o` equals `wr_i`. Loads may follow each other on back-to-back edges.
- R3: In interleaved order, `addr_o[1:0]` after the k-th advance equals the start bits XOR k. A start of 01 gives 01, 00, 11, 10.
- R4: In linear order, `addr_o[1:0]` after the k-th advance equals (start + k) mod 4. A start of 10 gives 10, 11, 00, 01.
- R5: The low bits wrap. The fifth beat of a burst equals the first, and advances may continue past it in the same order.
- R6: On an advance (`stall` = 0, `adv` = 1) during an active burst, `valid_o` stays 1, and `wr_o` and `addr_o[ADDR_W-1:2]` keep their loaded values. The values of `sel` and `wr_i` have no effect.
- R7: On an edge with `stall` = 0, `adv` = 0 and `sel` = 0, `valid_o` drops to 0 while `addr_o` and `wr_o` hold.
- R8: An advance while `valid_o` = 0 leaves `valid_o`, `addr_o` and `wr_o` unchanged. Only a load starts a new access.
- R9: On an edge with `stall` = 1, all outputs hold, whatever the other inputs do.
- R10: Changes of `order_sel` while `rst_n` is high do not change the step order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| order_sel | input | 1 | Step order, sampled during reset: 1 interleaved, 0 linear |
| stall | input | 1 | 1 = ignore this edge and hold all state |
| adv | input | 1 | 1 = advance the burst, 0 = load or deselect |
| sel | input | 1 | Combined chip select, used only on load cycles |
| wr_i | input | 1 | Access type for a load: 1 write, 0 read |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current beat address |
| wr_o | output | 1 | Access type held for the burst |
| valid_o | output | 1 | An access is active this beat |

## Verification
The bench builds the block with `ADDR_W` = 12. This keeps the addresses short enough to read, yet leaves ten upper bits. Any disturbance of those bits during an advance therefore shows up. The bench resets the block twice, once in each order. This lets it run full wrapping bursts from several start values in both orders. It also lets it test a change of the order input in the middle of a run. Stalls, deselects and idle advances are mixed between the bursts, and the select and write inputs are toggled during advances.

// File: rtl/burst_seq_pkg.sv
// Package: shared constants and types of the burst address sequencer.
// Assumes the burst covers exactly the two lowest address bits.
package burst_seq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/burst_ctrl.sv
// burst_ctrl: decides load, step and deselect on each edge and holds the
// start address, access type, active flag and the order chosen at reset.
// Assumes a synchronous active-low reset held for at least one edge.
module burst_ctrl
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              order_sel,
    input  logic              stall,
    input  logic              adv,
    input  logic              sel,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              load_go,
    output logic              step_go,
    output logic              active,
    output logic              wr_q,
    output order_e            order_q,
    output logic [ADDR_W-1:0] start_q
);
    // Edge qualification: a load needs select, a step needs an active burst.
    assign load_go = !stall && !adv && sel;
    assign step_go = !stall && adv && active;

    // Order register: written only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            order_q <= order_sel ? ORD_XOR : ORD_LINEAR;
    end

    // Access state: capture on load, drop on deselect, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            wr_q    <= 1'b0;
            start_q <= '0;
        end else if (!stall && !adv) begin
            active <= sel;
            if (sel) begin
                wr_q    <= wr_i;
                start_q <= addr_i;
            end
        end
    end

    assert_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv && !sel) |=> !active);

    assert_idle_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv && !active) |=> (!active && $stable(start_q) && $stable(wr_q)));
endmodule

// File: rtl/burst_beat.sv
// burst_beat: counts the beats of the current burst, modulo 2**BEAT_W.
// Assumes load and step are never requested on the same edge.
module burst_beat
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_go,
    input  logic              step_go,
    output logic [BEAT_W-1:0] beat_q
);
    // Beat counter: clear on load, wrap-increment on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= '0;
        else if (load_go)
            beat_q <= '0;
        else if (step_go)
            beat_q <= beat_q + 1'b1;
    end
endmodule

// File: rtl/burst_order.sv
// burst_order: maps the start bits and the beat count to the current low
// address bits, either as XOR (interleaved) or as a wrapping sum (linear).
// Purely combinational.
module burst_order
    import burst_seq_pkg::*;
(
    input  order_e            order_q,
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat_q,
    output logic [BEAT_W-1:0] low_o
);
    logic [BEAT_W-1:0] xor_lo;
    logic [BEAT_W-1:0] sum_lo;

    // One XOR per burst bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_lo[b] = start_lo[b] ^ beat_q[b];
    end

    // Wrapping sum of the start bits and the beat count.
    assign sum_lo = start_lo + beat_q;

    // Order select.
    always_comb begin
        low_o = (order_q == ORD_XOR) ? xor_lo : sum_lo;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// burst_addr_seq: top of the two-bit burst address sequencer. Joins the
// control, beat counter and order mapping and forms the full beat address.
// Assumes ADDR_W > 2 and a synchronous active-low reset.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              order_sel,
    input  logic              stall,
    input  logic              adv,
    input  logic              sel,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_o,
    output logic              valid_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load_go;
    logic              step_go;
    logic              active;
    logic              wr_q;
    order_e            order_q;
    logic [ADDR_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] low;

    burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .order_sel(order_sel),
        .stall    (stall),
        .adv      (adv),
        .sel      (sel),
        .wr_i     (wr_i),
        .addr_i   (addr_i),
        .load_go  (load_go),
        .step_go  (step_go),
        .active   (active),
        .wr_q     (wr_q),
        .order_q  (order_q),
        .start_q  (start_q)
    );

    burst_beat u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_go(load_go),
        .step_go(step_go),
        .beat_q (beat_q)
    );

    burst_order u_order (
        .order_q (order_q),
        .start_lo(start_q[BEAT_W-1:0]),
        .beat_q  (beat_q),
        .low_o   (low)
    );

    // Output assembly: fixed upper bits, sequenced low bits.
    assign addr_o  = {start_q[ADDR_W-1:BEAT_W], low};
    assign wr_o    = wr_q;
    assign valid_o = active;

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !adv && sel) |=>
            (valid_o && addr_o == $past(addr_i) && wr_o == $past(wr_i)));

    assert_adv_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv && valid_o) |=>
            (valid_o && $stable(wr_o) && $stable(addr_o[ADDR_W-1:BEAT_W])));

    // R3 and R4: bit 0 of the beat address flips on every advance in both orders.
    assert_step_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && adv && valid_o) |=> (addr_o[0] != $past(addr_o[0])));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(addr_o) && $stable(wr_o) && $stable(valid_o)));

    initial begin
        assert_width_R6: assert (HI_W > 0);
    end
endmodule

// File: tb/burst_addr_seq_tb.sv
// Scoreboard bench: the driver applies one edge of stimulus, updates a model
// built from the requirements and queues the expected outputs; the monitor
// compares them just after the edge.
module burst_addr_seq_tb;
    localparam int AW = 12;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic          v;
        logic          w;
        logic [AW-1:0] a;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          order_sel = 1'b1;
    logic          stall = 1'b0;
    logic          adv = 1'b0;
    logic          sel = 1'b0;
    logic          wr_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic          wr_o;
    logic          valid_o;

    int n_chk = 0;
    int n_bad = 0;
    exp_t q[$];

    // Model state.
    logic          m_xor = 1'b1;
    logic          m_v = 1'b0;
    logic          m_w = 1'b0;
    logic [AW-1:0] m_start = '0;
    logic [1:0]    m_beat = '0;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .stall(stall),
        .adv(adv), .sel(sel), .wr_i(wr_i), .addr_i(addr_i),
        .addr_o(addr_o), .wr_o(wr_o), .valid_o(valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic v, input logic w, input logic [AW-1:0] a);
        n_chk++;
        if (valid_o !== v || wr_o !== w || addr_o !== a) begin
            n_bad++;
            $display("FAIL %s: got valid=%b wr=%b addr=%h, want valid=%b wr=%b addr=%h",
                     tag, valid_o, wr_o, addr_o, v, w, a);
        end
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, e.v, e.w, e.a);
            end
        end
    end

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] lo;
        lo = m_xor ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
        return {m_start[AW-1:2], lo};
    endfunction

    // Driver: one edge of stimulus, model update, expected item queued.
    task automatic drive(input string tag, input logic s, input logic a_dv,
                         input logic c, input logic w, input logic [AW-1:0] ad);
        exp_t e;
        @(negedge clk);
        stall = s; adv = a_dv; sel = c; wr_i = w; addr_i = ad;
        if (!s) begin
            if (!a_dv) begin
                m_v = c;
                if (c) begin
                    m_start = ad; m_w = w; m_beat = 2'd0;
                end
            end else if (m_v) begin
                m_beat = m_beat + 2'd1;
            end
        end
        e.v = m_v; e.w = m_w; e.a = model_addr(); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset(input logic mode);
        wait (q.size() == 0);
        @(negedge clk);
        rst_n = 1'b0; order_sel = mode;
        stall = 1'b0; adv = 1'b0; sel = 1'b0; wr_i = 1'b0; addr_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_xor = mode; m_v = 1'b0; m_w = 1'b0; m_start = '0; m_beat = '0;
        check("R1 reset state", 1'b0, 1'b0, '0);
    endtask

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // Interleaved order.
        do_reset(1'b1);
        drive("R2 load write", 0, 0, 1, 1, 12'hA51);
        drive("R3 xor beat1 R6", 0, 1, 0, 0, 12'h000);
        drive("R3 xor beat2 R6", 0, 1, 1, 0, 12'hFFF);
        drive("R3 xor beat3", 0, 1, 0, 1, 12'h123);
        drive("R5 wrap xor", 0, 1, 0, 0, 12'h000);
        drive("R5 wrap continue", 0, 1, 1, 1, 12'h000);
        drive("R9 stall load", 1, 0, 1, 0, 12'h3C6);
        drive("R9 stall adv", 1, 1, 1, 1, 12'h7F3);
        drive("R2 back to back a", 0, 0, 1, 0, 12'h3C6);
        drive("R2 back to back b", 0, 0, 1, 1, 12'h7F3);
        drive("R3 xor start11", 0, 1, 0, 0, 12'h000);
        // R10: order input changes without reset; order stays interleaved.
        @(negedge clk); order_sel = 1'b0;
        drive("R10 load", 0, 0, 1, 0, 12'h5E1);
        drive("R10 xor kept b1", 0, 1, 0, 0, 12'h000);
        drive("R10 xor kept b2", 0, 1, 0, 0, 12'h000);
        drive("R7 deselect", 0, 0, 0, 1, 12'hBBB);
        drive("R8 idle adv 1", 0, 1, 1, 1, 12'h444);
        drive("R8 idle adv 2", 0, 1, 0, 0, 12'h444);
        drive("R8 reload after deselect", 0, 0, 1, 1, 12'h862);
        drive("R3 xor start10", 0, 1, 0, 0, 12'h000);
        // Linear order.
        do_reset(1'b0);
        drive("R2 load read", 0, 0, 1, 0, 12'h9A2);
        drive("R4 lin beat1 R6", 0, 1, 1, 1, 12'h000);
        drive("R4 lin beat2", 0, 1, 0, 1, 12'h000);
        drive("R9 stall mid burst", 1, 0, 0, 1, 12'h111);
        drive("R4 lin beat3", 0, 1, 0, 0, 12'h000);
        drive("R5 wrap lin", 0, 1, 0, 0, 12'h000);
        drive("R2 load start01", 0, 0, 1, 1, 12'h0C1);
        drive("R4 lin start01 b1", 0, 1, 0, 0, 12'h000);
        drive("R4 lin start01 b2", 0, 1, 0, 0, 12'h000);
        drive("R4 lin start01 b3", 0, 1, 0, 0, 12'h000);
        drive("R7 deselect lin", 0, 0, 0, 0, 12'h000);
        drive("R8 idle adv lin", 0, 1, 0, 1, 12'h000);
        wait (q.size() == 0);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule